// File: doc/BRIEF.md
# Four-Event Packing Buffer Across Two Clock Domains

This block sits at the front of an event-sensor datapath. Sensor events come in on the fast datapath clock with a valid strobe. A four-lane shift register gathers them, and every group becomes one wide packet. That packet is written into a dual-clock FIFO. Because one write covers four events, the write side only needs a slot at a quarter of the peak event rate.

The FIFO is sized from the total event capacity: with default settings it holds 256 packets, which is 1024 events. The reading side runs on the control clock and pops one packet per accepted read strobe. Each packet carries a count of the events it holds. A flush strobe pushes a partly filled group at the end of a frame. When storage is full, new events are thrown away and a sticky overflow flag records the loss until it is cleared.

Top module: `event_pack_fifo`

## Requirements
- R1: After reset, `empty` is 1, `full` is 0, `overflow` is 0 and `rd_valid` is 0.
- R2: Four accepted events form one packet. The earliest event sits in bits [EVENT_W-1:0], each later event sits in the next EVENT_W-bit lane up, and the count field (the CNT_W bits above the lanes) reads 4.
- R3: Packets leave the read port in the order they were pushed, with no loss and no duplication.
- R4: A flush with k = 1 to 3 held events pushes one packet with count k, those events in lanes 0 to k-1, and zeros in the unused lanes. A flush with no held events pushes nothing.
- R5: When an event and a flush come in the same cycle, the event joins the group before that group is pushed.
- R6: `full` rises in the write-clock cycle after the push that leaves MAX_EVENTS/LANES packets unread. It falls again once the reads have been seen across the clock boundary.
- R7: An event that arrives while `full` is 1 is discarded and never shows up in any packet.
- R8: A discarded event sets `overflow` at that write-clock edge. The flag stays at 1 until a cycle with `ovf_clr` and no discard clears it.
- R9: A read strobe while `empty` is 0 gives `rd_valid` for one cycle with the head packet on the next read-clock edge. A read strobe while `empty` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Datapath (event) clock |
| wrst_n | input | 1 | Active-low reset, datapath domain |
| ev_valid | input | 1 | Event strobe |
| ev_data | input | EVENT_W | Event word |
| flush | input | 1 | Push any partly filled group |
| ovf_clr | input | 1 | Clear the overflow flag |
| full | output | 1 | Storage full (datapath domain) |
| overflow | output | 1 | Sticky flag: events were discarded |
| rclk | input | 1 | Readout clock |
| rrst_n | input | 1 | Active-low reset, readout domain |
| rd_en | input | 1 | Read strobe |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | CNT_W+LANES*EVENT_W | Packet: {count, lane3..lane0} |
| empty | output | 1 | No packet available (readout domain) |

## Verification
The bench builds the block with 12-bit events, four lanes and a 64-event capacity, which gives a 16-packet FIFO. At that size the pointers wrap several times during normal streaming. Full storage can also be reached in a few dozen events, so discards, flag set and clear, and the release of `full` after draining are all tested quickly. The read clock is slower than and unrelated to the write clock. The reader is run in three modes: stalled, reading only when data is waiting, and strobing continuously even while the FIFO is empty.

// File: rtl/evpk_pkg.sv
package evpk_pkg;

   // Binary to reflected Gray code, 32-bit carrier; callers cast to width.
   function automatic logic [31:0] to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/evpk_sync.sv
module evpk_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/evpk_packer.sv
module evpk_packer #(
   parameter int EVENT_W = 16,
   parameter int LANES   = 4,
   parameter int CNT_W   = 3
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             ev_valid,
   input  logic [EVENT_W-1:0]               ev_data,
   input  logic                             flush,
   input  logic                             full,
   output logic                             push,
   output logic                             drop,
   output logic [CNT_W+LANES*EVENT_W-1:0]   pkt
);
   localparam int LW = LANES * EVENT_W;

   logic [LW-1:0]    lanes_q, shifted, lanes_d, aligned;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             accept;

   assign accept = ev_valid & ~full;
   assign drop   = ev_valid & full;

   // New event enters the top lane; older ones move one lane down.
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (i == LANES - 1) begin : g_top
         assign shifted[i*EVENT_W +: EVENT_W] = ev_data;
      end else begin : g_low
         assign shifted[i*EVENT_W +: EVENT_W] = lanes_q[(i+1)*EVENT_W +: EVENT_W];
      end
   end

   assign lanes_d = accept ? shifted : lanes_q;
   assign cnt_d   = cnt_q + CNT_W'(accept);

   // Held events occupy the top cnt_d lanes; move them to lane 0 upward.
   assign aligned = lanes_d >> (EVENT_W * (LANES - int'(cnt_d)));

   assign push = (cnt_d == CNT_W'(LANES)) ||
                 (flush && !full && (cnt_d != '0));
   assign pkt  = {cnt_d, aligned};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lanes_q <= '0;
         cnt_q   <= '0;
      end else begin
         lanes_q <= lanes_d;
         cnt_q   <= push ? '0 : cnt_d;
      end
   end
endmodule

// File: rtl/evpk_fifo.sv
module evpk_fifo #(
   parameter int DW          = 67,
   parameter int AW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic          full,
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          rd_en,
   output logic          rd_valid,
   output logic [DW-1:0] rdata,
   output logic          empty
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   logic [PW-1:0] wbin, wbin_n, wgray, wq;
   logic [PW-1:0] rbin, rbin_n, rgray, rq;
   logic          do_wr, do_rd;

   // write domain
   assign do_wr  = wr_en & ~full;
   assign wbin_n = wbin + PW'(do_wr);

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else begin
         wbin  <= wbin_n;
         wgray <= PW'(evpk_pkg::to_gray(32'(wbin_n)));
      end
   end

   always_ff @(posedge wclk) begin
      if (do_wr) mem[wbin[AW-1:0]] <= wdata;
   end

   evpk_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rq));

   assign full = (wgray == {~rq[AW:AW-1], rq[AW-2:0]});

   // read domain
   assign do_rd  = rd_en & ~empty;
   assign rbin_n = rbin + PW'(do_rd);

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin     <= '0;
         rgray    <= '0;
         rd_valid <= 1'b0;
         rdata    <= '0;
      end else begin
         rbin     <= rbin_n;
         rgray    <= PW'(evpk_pkg::to_gray(32'(rbin_n)));
         rd_valid <= do_rd;
         if (do_rd) rdata <= mem[rbin[AW-1:0]];
      end
   end

   evpk_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wq));

   assign empty = (rgray == wq);
endmodule

// File: rtl/event_pack_fifo.sv
module event_pack_fifo #(
   parameter int EVENT_W     = 16,
   parameter int LANES       = 4,
   parameter int MAX_EVENTS  = 1024,
   parameter int SYNC_STAGES = 2,
   localparam int CNT_W      = $clog2(LANES + 1),
   localparam int PKT_W      = CNT_W + LANES * EVENT_W
) (
   input  logic               wclk,
   input  logic               wrst_n,
   input  logic               ev_valid,
   input  logic [EVENT_W-1:0] ev_data,
   input  logic               flush,
   input  logic               ovf_clr,
   output logic               full,
   output logic               overflow,
   input  logic               rclk,
   input  logic               rrst_n,
   input  logic               rd_en,
   output logic               rd_valid,
   output logic [PKT_W-1:0]   rd_data,
   output logic               empty
);
   localparam int DEPTH = MAX_EVENTS / LANES;
   localparam int AW    = $clog2(DEPTH);

   if (LANES < 2) begin : g_bad_lanes
      $error("LANES must be at least 2");
   end
   if ((MAX_EVENTS % LANES) != 0) begin : g_bad_ratio
      $error("MAX_EVENTS must be a multiple of LANES");
   end
   if (!evpk_pkg::is_pow2(DEPTH) || DEPTH < 4) begin : g_bad_depth
      $error("MAX_EVENTS/LANES must be a power of two, at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             pkt_push, ev_drop;
   logic [PKT_W-1:0] pkt_bus;
   logic [CNT_W-1:0] pkt_cnt;
   logic             ovf_q;

   evpk_packer #(.EVENT_W(EVENT_W), .LANES(LANES), .CNT_W(CNT_W)) u_pack (
      .clk(wclk), .rst_n(wrst_n),
      .ev_valid(ev_valid), .ev_data(ev_data), .flush(flush), .full(full),
      .push(pkt_push), .drop(ev_drop), .pkt(pkt_bus));

   assign pkt_cnt = pkt_bus[PKT_W-1 -: CNT_W];

   evpk_fifo #(.DW(PKT_W), .AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
      .wclk(wclk), .wrst_n(wrst_n), .wr_en(pkt_push), .wdata(pkt_bus), .full(full),
      .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_valid(rd_valid),
      .rdata(rd_data), .empty(empty));

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n)      ovf_q <= 1'b0;
      else if (ev_drop) ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
   end

   assign overflow = ovf_q;
endmodule

// File: rtl/evpk_checker.sv
module evpk_checker #(
   parameter int LANES = 4,
   parameter int CNT_W = 3
) (
   input logic             wclk,
   input logic             wrst_n,
   input logic             rclk,
   input logic             rrst_n,
   input logic             ev_valid,
   input logic             ovf_clr,
   input logic             full,
   input logic             overflow,
   input logic             push,
   input logic [CNT_W-1:0] pkt_cnt,
   input logic             rd_en,
   input logic             empty,
   input logic             rd_valid
);
   a_r7_no_push_when_full: assert property (@(posedge wclk) disable iff (!wrst_n)
      push |-> !full);

   a_r4_count_in_range: assert property (@(posedge wclk) disable iff (!wrst_n)
      push |-> (pkt_cnt >= 1) && (pkt_cnt <= CNT_W'(LANES)));

   a_r8_drop_sets_flag: assert property (@(posedge wclk) disable iff (!wrst_n)
      (ev_valid && full) |=> overflow);

   a_r8_flag_sticky: assert property (@(posedge wclk) disable iff (!wrst_n)
      (overflow && !ovf_clr) |=> overflow);

   a_r8_flag_needs_drop: assert property (@(posedge wclk) disable iff (!wrst_n)
      (!overflow && !(ev_valid && full)) |=> !overflow);

   a_r9_read_gives_valid: assert property (@(posedge rclk) disable iff (!rrst_n)
      (rd_en && !empty) |=> rd_valid);

   a_r9_no_valid_without_read: assert property (@(posedge rclk) disable iff (!rrst_n)
      !(rd_en && !empty) |=> !rd_valid);
endmodule

bind event_pack_fifo evpk_checker #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
   .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
   .ev_valid(ev_valid), .ovf_clr(ovf_clr), .full(full), .overflow(overflow),
   .push(pkt_push), .pkt_cnt(pkt_cnt), .rd_en(rd_en), .empty(empty),
   .rd_valid(rd_valid));

// File: tb/event_pack_fifo_test.sv
`timescale 1ns/1ps
module event_pack_fifo_test;
   localparam int EW    = 12;
   localparam int LN    = 4;
   localparam int MAXE  = 64;
   localparam int CW    = $clog2(LN + 1);
   localparam int PW    = CW + LN * EW;
   localparam int DEPTH = MAXE / LN;

   logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
   logic ev_valid = 0, flush = 0, ovf_clr = 0, rd_en = 0;
   logic [EW-1:0] ev_data = '0;
   logic full, overflow, rd_valid, empty;
   logic [PW-1:0] rd_data;

   always #2 wclk = ~wclk;   // 250 MHz
   always #3 rclk = ~rclk;

   event_pack_fifo #(.EVENT_W(EW), .LANES(LN), .MAX_EVENTS(MAXE)) uut (
      .wclk(wclk), .wrst_n(wrst_n), .ev_valid(ev_valid), .ev_data(ev_data),
      .flush(flush), .ovf_clr(ovf_clr), .full(full), .overflow(overflow),
      .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_valid(rd_valid),
      .rd_data(rd_data), .empty(empty));

   int checks = 0, errors = 0, pushed = 0, popped = 0, rd_mode = 0;
   bit done = 0;
   logic [PW-1:0] sb [$];
   logic [EW-1:0] held [$];

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: compares every delivered packet against the scoreboard
   always @(negedge rclk) begin
      if (rrst_n) begin
         if (rd_valid) begin
            if (sb.size() == 0) begin
               chk(0, "R9 unexpected rd_valid", longint'(rd_data), 0);
            end else begin
               logic [PW-1:0] e;
               e = sb.pop_front();
               popped++;
               chk(rd_data == e, "R2/R3 packet content and order", longint'(rd_data), longint'(e));
            end
         end
         rd_en = (rd_mode == 2) ? 1'b1 : (rd_mode == 1) ? !empty : 1'b0;
      end
   end

   function automatic logic [PW-1:0] make_pkt();
      logic [PW-1:0] p = '0;
      for (int i = 0; i < held.size(); i++) p[i*EW +: EW] = held[i];
      p[PW-1 -: CW] = CW'(held.size());
      return p;
   endfunction

   // driver: applies one write-clock cycle and updates the model
   task automatic drive(input logic v, input logic [EW-1:0] d, input logic fl);
      bit mfull;
      @(negedge wclk);
      ev_valid = v; ev_data = d; flush = fl;
      mfull = (pushed - popped) == DEPTH;
      if (v && !mfull) held.push_back(d);
      if (held.size() == LN || (fl && held.size() > 0 && !mfull)) begin
         sb.push_back(make_pkt());
         pushed++;
         held.delete();
      end
      @(posedge wclk);
      #1 ev_valid = 0; flush = 0;
   endtask

   task automatic wait_drain();
      int n = 0;
      while (sb.size() != 0 && n < 3000) begin
         @(negedge rclk);
         n++;
      end
      chk(sb.size() == 0, "R3 all packets delivered", sb.size(), 0);
      repeat (8) @(negedge rclk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #150000;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(posedge wclk);
      wrst_n = 1; rrst_n = 1;
      @(negedge wclk);
      chk(empty == 1, "R1 empty after reset", empty, 1);
      chk(full == 0, "R1 full after reset", full, 0);
      chk(overflow == 0, "R1 overflow after reset", overflow, 0);
      chk(rd_valid == 0, "R1 rd_valid after reset", rd_valid, 0);

      // R2 R3: back-to-back stream
      rd_mode = 1;
      for (int i = 0; i < 40; i++) drive(1, EW'(12'h100 + i), 0);
      wait_drain();

      // R4: sparse events, trailing single event flushed
      for (int i = 0; i < 13; i++) begin
         drive(1, EW'(12'hA00 + i * 7), 0);
         drive(0, '0, 0);
         if (i % 3 == 0) drive(0, '0, 0);
      end
      drive(0, '0, 1);
      // R4: groups of two and three, then an empty flush
      drive(1, 12'h0C1, 0); drive(1, 12'h0C2, 0); drive(0, '0, 1);
      drive(1, 12'h0D1, 0); drive(1, 12'h0D2, 0); drive(1, 12'h0D3, 0); drive(0, '0, 1);
      drive(0, '0, 1);
      // R5: event together with flush
      drive(1, 12'h0E1, 0); drive(1, 12'h0E2, 0); drive(1, 12'h0E3, 1);
      wait_drain();

      // R6 R7 R8: fill with reader stalled
      rd_mode = 0;
      repeat (4) @(negedge rclk);
      for (int i = 0; i < MAXE - 1; i++) drive(1, EW'(12'h300 + i), 0);
      @(negedge wclk);
      chk(full == 0, "R6 full before last packet", full, 0);
      drive(1, 12'h3FF, 0);
      @(negedge wclk);
      chk(full == 1, "R6 full at capacity", full, 1);
      chk(overflow == 0, "R8 no overflow before drop", overflow, 0);
      for (int i = 0; i < 5; i++) drive(1, EW'(12'hBAD), 0);
      @(negedge wclk);
      chk(overflow == 1, "R8 overflow after drop", overflow, 1);
      chk(full == 1, "R6 full holds while unread", full, 1);
      repeat (3) drive(0, '0, 0);
      chk(overflow == 1, "R8 overflow sticky", overflow, 1);
      @(negedge wclk); ovf_clr = 1; @(posedge wclk); #1 ovf_clr = 0;
      @(negedge wclk);
      chk(overflow == 0, "R8 overflow cleared", overflow, 0);
      drive(1, EW'(12'hBAD), 0);
      @(negedge wclk);
      chk(overflow == 1, "R8 overflow set again", overflow, 1);
      @(negedge wclk); ovf_clr = 1; @(posedge wclk); #1 ovf_clr = 0;
      rd_mode = 1;
      wait_drain();
      repeat (6) @(negedge wclk);
      chk(full == 0, "R6 full released after drain", full, 0);
      for (int i = 0; i < LN; i++) drive(1, EW'(12'h700 + i), 0);
      wait_drain();

      // R9: read strobe held high while empty
      rd_mode = 2;
      for (int i = 0; i < 5; i++) begin
         @(negedge rclk);
         chk(rd_valid == 0, "R9 no data while empty", rd_valid, 0);
      end
      for (int i = 0; i < 10; i++) drive(1, EW'(12'h900 + i), 0);
      drive(0, '0, 1);
      wait_drain();
      chk(held.size() == 0, "R4 nothing left held", held.size(), 0);
      rd_mode = 0;
      finish_run();
   end
endmodule